// File: doc/BRIEF.md
# Write Leveling Training Sequencer

This block runs the write-leveling search for one memory device from the controller side. On `start` it sends a mode-register command that puts the device into leveling mode. It then steps a DQS launch delay tap upward from zero. For each tap it waits a settle interval, fires a short burst of DQS pulses, and takes back the one-bit clock level that the device captured on DQ. The search ends at the first tap that returns 1 right after a tap that returned 0. That tap is held on `dly_tap` as the result. A second mode-register command takes the device out of leveling mode, and `done` pulses.

Two flows use valid/ready: the mode-register command and the returned sample. A command stays valid, with a constant payload, until the PHY accepts it. The PHY may hold `mr_ready` low for any number of cycles. The sequencer raises `samp_ready` only while it waits for a sample. A `samp_valid` seen without `samp_ready` carries nothing and is dropped. The PHY may hold back `samp_valid` for as long as it needs. The handshake lines `start`, `done` and `err` are plain levels or pulses.

Top module: `wl_seq`

## Requirements
- R1: After reset, `mr_valid`, `dqs_pulse`, `samp_ready`, `done` and `err` are 0 and `dly_tap` is 0.
- R2: A `start` seen while idle clears `err`, sets `dly_tap` to 0 and presents a mode-register command. The command has `mr_sel` = 1 and `mr_data` = `MR1_BASE` with bit 7 set. It holds valid and stable until the cycle in which `mr_ready` is high.
- R3: After the entry command is accepted, and after every tap increment, the block drives no DQS pulse for exactly `SETTLE_CYC` cycles (default 16).
- R4: Each burst drives `dqs_pulse` high for `BURST_LEN` consecutive cycles. In the next cycle `samp_ready` goes high and stays high until a sample is accepted. `dqs_pulse` and `samp_ready` are never high together.
- R5: A sample is taken only in a cycle where `samp_valid` and `samp_ready` are both high. `samp_valid` at any other time has no effect on the outputs.
- R6: When the accepted sample is 1 and the sample accepted at the previous tap was 0, the search stops and `dly_tap` keeps the current tap. Any other accepted sample below the top tap raises `dly_tap` by exactly 1.
- R7: A sample of 1 at tap 0 is never a transition, because no earlier sample exists. A 1 that follows a 1 is not a transition either.
- R8: When a sample at tap 2^`TAP_W`-1 gives no transition, `err` is set and the block finishes with `dly_tap` at that top tap. `err` stays high until the next accepted `start`.
- R9: To finish, the block presents a mode-register command with `mr_sel` = 1 and `mr_data` = `MR1_BASE` with bit 7 cleared. The command follows the same hold rule as R2. In the cycle after it is accepted, `done` is high for exactly one cycle, and the block then returns to idle.
- R10: A `start` that arrives while a search is running has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (taken only when idle) |
| done | output | 1 | One-cycle pulse at the end of a search |
| err | output | 1 | No 0-to-1 transition was found; held until the next start |
| mr_valid | output | 1 | Mode-register command valid |
| mr_ready | input | 1 | Mode-register command accepted |
| mr_sel | output | SEL_W | Mode register index (always 1) |
| mr_data | output | MR_W | Mode register payload |
| dqs_pulse | output | 1 | DQS pulse strobe, one pulse per cycle while high |
| samp_valid | input | 1 | Returned clock sample valid |
| samp_ready | output | 1 | Block waits for a sample |
| samp_bit | input | 1 | Clock level captured by the device |
| dly_tap | output | TAP_W | DQS delay tap in use, and the result after done |

## Verification
The embedded assertions check on every cycle that a stalled command holds steady and addresses register 1, and that each burst starts only when the settle interval ends. They also check that pulses and sample waits never overlap, that the tap only steps by one or clears, that `done` lasts a single cycle and that `err` drops only on a start. Whether the search stops at the right tap can only be shown by the bench scenarios. The same holds for ignoring a 1 at tap 0 or after another 1, running out of taps, dropping stray samples and ignoring starts while busy. Each of these depends on the sequence of device responses the bench emulates, under different stalls on both handshakes.

// File: rtl/wl_pkg.sv
package wl_pkg;

  typedef enum logic [2:0] {
    WL_IDLE   = 3'd0,
    WL_MR_ON  = 3'd1,
    WL_SETTLE = 3'd2,
    WL_BURST  = 3'd3,
    WL_SAMPLE = 3'd4,
    WL_MR_OFF = 3'd5,
    WL_FINISH = 3'd6
  } wl_state_e;

  localparam int unsigned WL_MR_INDEX = 1;

endpackage

// File: rtl/wl_phase_cnt.sv
module wl_phase_cnt #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] FINAL = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || last)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign last = run && (cnt_q == FINAL);

  // phase length bound (R3, R4)
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= FINAL));

endmodule

// File: rtl/wl_step_judge.sv
module wl_step_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic take,
  input  logic bit_in,
  output logic rise
);
  logic prev_q;
  logic have_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else if (clear) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else if (take) begin
      prev_q <= bit_in;
      have_q <= 1'b1;
    end
  end

  // a 1 is a transition only when an earlier 0 exists (R6, R7)
  assign rise = have_q && !prev_q && bit_in;

endmodule

// File: rtl/wl_mr_word.sv
module wl_mr_word #(
  parameter int unsigned MR_W     = 14,
  parameter logic [MR_W-1:0] BASE = '0,
  parameter int unsigned LVL_BIT  = 7
) (
  input  logic            lvl_on,
  output logic [MR_W-1:0] word
);
  always_comb begin
    word          = BASE;
    word[LVL_BIT] = lvl_on;
  end
endmodule

// File: rtl/wl_seq.sv
module wl_seq
  import wl_pkg::*;
#(
  parameter int unsigned TAP_W       = 6,
  parameter int unsigned SETTLE_CYC  = 16,
  parameter int unsigned BURST_LEN   = 4,
  parameter int unsigned MR_W        = 14,
  parameter int unsigned SEL_W       = 3,
  parameter logic [MR_W-1:0] MR1_BASE = '0,
  parameter int unsigned LVL_BIT     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             done,
  output logic             err,
  output logic             mr_valid,
  input  logic             mr_ready,
  output logic [SEL_W-1:0] mr_sel,
  output logic [MR_W-1:0]  mr_data,
  output logic             dqs_pulse,
  input  logic             samp_valid,
  output logic             samp_ready,
  input  logic             samp_bit,
  output logic [TAP_W-1:0] dly_tap
);
  localparam logic [TAP_W-1:0] TAP_TOP = '1;
  localparam logic [SEL_W-1:0] SEL_MR1 = SEL_W'(WL_MR_INDEX);

  wl_state_e        state_q, state_d;
  logic [TAP_W-1:0] tap_q;
  logic             err_q;
  logic             settle_last, burst_last, rise_hit;
  logic             start_acc, samp_acc, mr_acc;

  assign start_acc = (state_q == WL_IDLE) && start;
  assign samp_acc  = (state_q == WL_SAMPLE) && samp_valid;
  assign mr_acc    = mr_valid && mr_ready;

  wl_phase_cnt #(.LEN(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(state_q == WL_SETTLE), .last(settle_last));

  wl_phase_cnt #(.LEN(BURST_LEN)) u_burst (
    .clk(clk), .rst_n(rst_n), .run(state_q == WL_BURST), .last(burst_last));

  wl_step_judge u_judge (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .take(samp_acc),
    .bit_in(samp_bit), .rise(rise_hit));

  wl_mr_word #(.MR_W(MR_W), .BASE(MR1_BASE), .LVL_BIT(LVL_BIT)) u_word (
    .lvl_on(state_q == WL_MR_ON), .word(mr_data));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WL_IDLE:   if (start)       state_d = WL_MR_ON;
      WL_MR_ON:  if (mr_ready)    state_d = WL_SETTLE;
      WL_SETTLE: if (settle_last) state_d = WL_BURST;
      WL_BURST:  if (burst_last)  state_d = WL_SAMPLE;
      WL_SAMPLE: if (samp_valid) begin
        if (rise_hit || tap_q == TAP_TOP) state_d = WL_MR_OFF;
        else                              state_d = WL_SETTLE;
      end
      WL_MR_OFF: if (mr_ready)    state_d = WL_FINISH;
      WL_FINISH:                  state_d = WL_IDLE;
      default:                    state_d = WL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WL_IDLE;
      tap_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_acc) begin
        tap_q <= '0;
        err_q <= 1'b0;
      end else if (samp_acc && !rise_hit) begin
        if (tap_q == TAP_TOP) err_q <= 1'b1;
        else                  tap_q <= tap_q + 1'b1;
      end
    end
  end

  assign mr_valid   = (state_q == WL_MR_ON) || (state_q == WL_MR_OFF);
  assign mr_sel     = SEL_MR1;
  assign dqs_pulse  = (state_q == WL_BURST);
  assign samp_ready = (state_q == WL_SAMPLE);
  assign done       = (state_q == WL_FINISH);
  assign err        = err_q;
  assign dly_tap    = tap_q;

  assert_mr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_valid && !mr_acc) |=> (mr_valid && $stable(mr_data)));

  assert_mr_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mr_valid |-> (mr_sel == SEL_MR1));

  assert_burst_after_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqs_pulse) |-> $past(settle_last));

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dqs_pulse && samp_ready));

  assert_tap_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dly_tap) |-> ((dly_tap == $past(dly_tap) + 1'b1) || (dly_tap == '0)));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(start));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sim_wl_seq.sv
module sim_wl_seq;
  localparam int TAP_W  = 6;
  localparam int SETTLE = 16;
  localparam int NPULSE = 4;
  localparam int MR_W   = 14;
  localparam int TOP    = (1 << TAP_W) - 1;
  localparam logic [MR_W-1:0] BASE = 14'h0203;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic mr_ready = 1'b0, samp_valid = 1'b0, samp_bit = 1'b0;
  logic done, err, mr_valid, dqs_pulse, samp_ready;
  logic [2:0] mr_sel;
  logic [MR_W-1:0] mr_data;
  logic [TAP_W-1:0] dly_tap;

  always #4 clk = ~clk;

  wl_seq #(.TAP_W(TAP_W), .SETTLE_CYC(SETTLE), .BURST_LEN(NPULSE),
           .MR_W(MR_W), .SEL_W(3), .MR1_BASE(BASE), .LVL_BIT(7)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
    .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_sel(mr_sel), .mr_data(mr_data),
    .dqs_pulse(dqs_pulse), .samp_valid(samp_valid), .samp_ready(samp_ready),
    .samp_bit(samp_bit), .dly_tap(dly_tap));

  int vecs = 0, fails = 0, cyc = 0;
  int mode = 0, thr = 0, mr_lat = 0, s_lat = 0, stray = 0;
  int mw = 0, sw = 0;

  // behavioural reference: phase 0 idle,1 enter,2 settle,3 burst,4 wait,5 leave,6 finish
  int ph = 0, pc = 0, m_tap = 0, prv = -1, m_err = 0;

  task automatic check(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic device(int t);
    case (mode)
      0: return t >= thr;
      1: return 1'b1;
      2: return 1'b0;
      default: return (t < 2) ? 1'b1 : (t >= thr);
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
    if (!rst_n) begin
      ph = 0; pc = 0; m_tap = 0; prv = -1; m_err = 0;
    end else begin
      case (ph)
        0: if (start) begin ph = 1; m_tap = 0; prv = -1; m_err = 0; end
        1: if (mr_ready) begin ph = 2; pc = 0; end
        2: begin pc++; if (pc == SETTLE) begin ph = 3; pc = 0; end end
        3: begin pc++; if (pc == NPULSE) ph = 4; end
        4: if (samp_valid) begin
             if (prv == 0 && samp_bit) ph = 5;
             else if (m_tap == TOP) begin m_err = 1; ph = 5; end
             else begin m_tap++; prv = samp_bit; ph = 2; pc = 0; end
           end
        5: if (mr_ready) ph = 6;
        default: ph = 0;
      endcase
    end
  end

  // compare every cycle, then emulate the PHY/device side
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2/R9 mr_valid", mr_valid, (ph == 1 || ph == 5));
      if (mr_valid) begin
        check("R2 mr_sel", mr_sel, 1);
        check("R2/R9 mr_data", mr_data, (ph == 1) ? (BASE | 14'h80) : (BASE & ~14'h80));
      end
      check("R3/R4 dqs_pulse", dqs_pulse, ph == 3);
      check("R4/R5 samp_ready", samp_ready, ph == 4);
      check("R6 dly_tap", dly_tap, m_tap);
      check("R8 err", err, m_err);
      check("R9 done", done, ph == 6);
    end
    if (mr_valid) begin
      if (mw >= mr_lat) begin mr_ready = 1'b1; mw = 0; end
      else begin mr_ready = 1'b0; mw++; end
    end else begin
      mr_ready = stray[0]; mw = 0;
    end
    if (samp_ready) begin
      if (sw >= s_lat) begin samp_valid = 1'b1; samp_bit = device(int'(dly_tap)); sw = 0; end
      else begin samp_valid = 1'b0; sw++; end
    end else begin
      sw = 0;
      samp_valid = (stray != 0);   // R5: stray samples must be dropped
      samp_bit   = 1'b1;
    end
  end

  task automatic run(int md, int th, int ml, int sl, int st, int poke,
                     int exp_tap, int exp_err, string tag);
    mode = md; thr = th; mr_lat = ml; s_lat = sl; stray = st;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (poke != 0 && i == poke) start = 1'b1;   // R10
      else start = 1'b0;
      if (done) break;
      @(negedge clk);
    end
    start = 1'b0;
    check({tag, " done seen"}, done, 1);
    check({tag, " result tap"}, dly_tap, exp_tap);
    check({tag, " error flag"}, err, exp_err);
    @(negedge clk);
    check({tag, " done one cycle R9"}, done, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mr_valid", mr_valid, 0);
    check("R1 dqs_pulse", dqs_pulse, 0);
    check("R1 samp_ready", samp_ready, 0);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 dly_tap", dly_tap, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(0, 5, 0, 0, 0, 0, 5, 0, "R6 plain");
    run(0, 9, 3, 2, 0, 0, 9, 0, "R2 stalled");
    run(3, 6, 1, 0, 0, 0, 6, 0, "R7 early ones");
    run(0, 3, 0, 1, 1, 0, 3, 0, "R5 stray");
    run(0, 12, 0, 0, 0, 40, 12, 0, "R10 busy start");
    run(1, 0, 0, 0, 0, 0, TOP, 1, "R8 all ones");
    run(2, 0, 2, 0, 0, 0, TOP, 1, "R8 all zeros");
    run(0, TOP, 0, 0, 0, 0, TOP, 0, "R6 top tap");
    run(0, 1, 0, 0, 0, 0, 1, 0, "R3 first step");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule